// File: doc/BRIEF.md
# Scan-to-Debug-Bus Bridge

This block lets a host that only has a boundary-scan port reach an 8-bit-address, 64-bit-data debug register bus. A single 74-bit user data register in the test clock domain carries each command. It is shifted least-significant bit first: a 2-bit operation code, then 64 data bits, then an 8-bit address. The operation codes are 0 for no operation (poll), 1 for read and 2 for write, and 3 is reserved. When the scan ends (update), a read or write is handed to the system clock domain, where a small state machine runs one debug-bus transaction.

Each capture loads the status into bits 1:0 and the latest read data into bits 65:2. Bits 73:66 capture as zero. The status is 0 when the bridge is idle or the last operation has finished, and 3 while an operation is still pending. The host issues poll scans until the status returns to 0, and takes the read data from that same scan. The request and the completion each cross clock domains as a toggle that passes through a two-flop synchronizer.

The system-side controller has three states. IDLE waits for a new request toggle and latches the command (transition "accept"). ISSUE holds the bus request until the target acknowledges, and captures read data on the acknowledge (transition "finish"). DONE flips the completion toggle and goes back to IDLE (transition "release").

Top module: `dbg_scan_bridge`

## Requirements
- R1: After reset, a capture returns status 0, read data 0 and address field 0.
- R2: An update with op 1 while idle starts exactly one bus read of the scanned address (bus write flag low). A later poll scan that reports status 0 returns the read data in bits 65:2.
- R3: An update with op 2 while idle starts exactly one bus write with the scanned address (bits 73:66) and data (bits 65:2).
- R4: The capture of the first scan after a launching update always reports status 3. Once the bus transaction has finished, a capture reports status 0.
- R5: A read or write update made while an operation is pending is ignored. It starts no bus transaction, and its address and data are never used.
- R6: Op 0 and op 3 start no bus transaction and leave the held read data unchanged.
- R7: Scan bits enter on tdi and leave on tdo least-significant bit first, so the first bit shifted out is status bit 0.
- R8: The bus request stays asserted with stable address, data and write flag until acknowledged, and is dropped in the cycle after the acknowledge.
- R9: The held read data changes only when a read completes. A write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst_n | input | 1 | Active-low reset, test clock domain |
| dr_sel | input | 1 | The bridge's data register is selected |
| dr_capture | input | 1 | Capture strobe |
| dr_shift | input | 1 | Shift strobe |
| dr_update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, system domain |
| dbus_req | output | 1 | Debug bus request |
| dbus_wr | output | 1 | 1 = write, 0 = read |
| dbus_addr | output | 8 | Debug register address |
| dbus_wdata | output | 64 | Write data |
| dbus_rdata | input | 64 | Read data from target |
| dbus_ack | input | 1 | Target acknowledge, one cycle |

## Verification
If the toggle pair falls out of step, the status field sticks at 3 or never shows 3. This is visible in the capture of the very next scan after a launch, and in the poll that follows it. A bad busy gate shows up as a second bus transaction or an overwritten register, and the bench sees that by counting bus acknowledges and reading the location back. Held read data that is corrupted or updated at the wrong time appears in bits 65:2 of the first poll that reports status 0.

// File: rtl/dbg_bridge_pkg.sv
package dbg_bridge_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_RSV = 2'd3
    } bridge_op_e;

    localparam logic [1:0] STAT_IDLE = 2'd0;
    localparam logic [1:0] STAT_BUSY = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DONE  = 2'd2
    } bus_state_e;
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dbg_scan_side.sv
module dbg_scan_side
    import dbg_bridge_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 64
) (
    input  logic          tck,
    input  logic          tck_rst_n,
    input  logic          dr_sel,
    input  logic          dr_capture,
    input  logic          dr_shift,
    input  logic          dr_update,
    input  logic          tdi,
    output logic          tdo,
    input  logic          ack_tgl_s,
    input  logic [DW-1:0] rdata_sys,
    output logic          req_tgl,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata
);
    localparam int OPW   = 2;
    localparam int SRLEN = OPW + DW + AW;

    logic [SRLEN-1:0] sr;
    logic [DW-1:0]    rd_hold;
    logic [OPW-1:0]   in_op;
    logic             busy;
    logic             launch;

    assign busy   = req_tgl ^ ack_tgl_s;
    assign in_op  = sr[OPW-1:0];
    assign launch = dr_sel && dr_update && !busy &&
                    (in_op == OP_RD || in_op == OP_WR);
    assign tdo    = sr[0];

    always_ff @(posedge tck or negedge tck_rst_n) begin
        if (!tck_rst_n) begin
            sr        <= '0;
            rd_hold   <= '0;
            req_tgl   <= 1'b0;
            cmd_wr    <= 1'b0;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
        end else begin
            if (!busy)
                rd_hold <= rdata_sys;
            if (dr_sel && dr_capture)
                sr <= {{AW{1'b0}}, (busy ? rd_hold : rdata_sys),
                       (busy ? STAT_BUSY : STAT_IDLE)};
            else if (dr_sel && dr_shift)
                sr <= {tdi, sr[SRLEN-1:1]};
            if (launch) begin
                req_tgl   <= ~req_tgl;
                cmd_wr    <= (in_op == OP_WR);
                cmd_addr  <= sr[SRLEN-1 -: AW];
                cmd_wdata <= sr[OPW +: DW];
            end
        end
    end

    // R4: a launch makes the bridge busy on the next test clock
    p_launch_busy_r4: assert property (@(posedge tck) disable iff (!tck_rst_n)
        launch |=> busy);
    // R5: an update while busy leaves request and command untouched
    p_busy_ignored_r5: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (dr_sel && dr_update && busy) |=>
            ($stable(req_tgl) && $stable(cmd_addr) && $stable(cmd_wdata)));
    // R6: op 0 and op 3 never toggle the request
    p_nop_no_launch_r6: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (dr_sel && dr_update && (in_op == OP_NOP || in_op == OP_RSV)) |=>
            $stable(req_tgl));
endmodule

// File: rtl/dbg_bus_fsm.sv
module dbg_bus_fsm
    import dbg_bridge_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tgl_s,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          ack_tgl,
    output logic [DW-1:0] rdata_q,
    output logic          dbus_req,
    output logic          dbus_wr,
    output logic [AW-1:0] dbus_addr,
    output logic [DW-1:0] dbus_wdata,
    input  logic [DW-1:0] dbus_rdata,
    input  logic          dbus_ack
);
    bus_state_e    st, st_nx;
    logic          seen;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          new_req;

    assign new_req = (req_tgl_s != seen);

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (new_req)  st_nx = S_ISSUE;
            S_ISSUE: if (dbus_ack) st_nx = S_DONE;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_tgl <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (new_req) begin
                    seen    <= req_tgl_s;
                    wr_q    <= cmd_wr;
                    addr_q  <= cmd_addr;
                    wdata_q <= cmd_wdata;
                end
                S_ISSUE: if (dbus_ack && !wr_q) rdata_q <= dbus_rdata;
                S_DONE:  ack_tgl <= ~ack_tgl;
                default: ;
            endcase
        end
    end

    always_comb begin
        dbus_req   = (st == S_ISSUE);
        dbus_wr    = wr_q;
        dbus_addr  = addr_q;
        dbus_wdata = wdata_q;
    end

    // R8: request held with stable command until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_req && !dbus_ack) |=>
            (dbus_req && $stable(dbus_addr) && $stable(dbus_wdata) && $stable(dbus_wr)));
    // R8: request dropped right after acknowledge
    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_req && dbus_ack) |=> !dbus_req);
    // R9: read data changes only on a read acknowledge
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbus_req && dbus_ack && !dbus_wr) |=> $stable(rdata_q));
    // R4: completion toggle flips when leaving DONE
    p_done_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE) |=> (ack_tgl != $past(ack_tgl)));
endmodule

// File: rtl/dbg_scan_bridge.sv
module dbg_scan_bridge #(
    parameter int AW = 8,
    parameter int DW = 64
) (
    input  logic          tck,
    input  logic          tck_rst_n,
    input  logic          dr_sel,
    input  logic          dr_capture,
    input  logic          dr_shift,
    input  logic          dr_update,
    input  logic          tdi,
    output logic          tdo,
    input  logic          clk,
    input  logic          rst_n,
    output logic          dbus_req,
    output logic          dbus_wr,
    output logic [AW-1:0] dbus_addr,
    output logic [DW-1:0] dbus_wdata,
    input  logic [DW-1:0] dbus_rdata,
    input  logic          dbus_ack
);
    logic          req_tgl, req_tgl_s;
    logic          ack_tgl, ack_tgl_s;
    logic          cmd_wr;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic [DW-1:0] rdata_q;

    dbg_scan_side #(.AW(AW), .DW(DW)) u_scan (
        .tck(tck), .tck_rst_n(tck_rst_n),
        .dr_sel(dr_sel), .dr_capture(dr_capture), .dr_shift(dr_shift),
        .dr_update(dr_update), .tdi(tdi), .tdo(tdo),
        .ack_tgl_s(ack_tgl_s), .rdata_sys(rdata_q),
        .req_tgl(req_tgl), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata)
    );

    dbg_sync2 #(.W(1)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_tgl_s)
    );

    dbg_sync2 #(.W(1)) u_ack_sync (
        .clk(tck), .rst_n(tck_rst_n), .d(ack_tgl), .q(ack_tgl_s)
    );

    dbg_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_tgl_s(req_tgl_s), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .ack_tgl(ack_tgl), .rdata_q(rdata_q),
        .dbus_req(dbus_req), .dbus_wr(dbus_wr), .dbus_addr(dbus_addr),
        .dbus_wdata(dbus_wdata), .dbus_rdata(dbus_rdata), .dbus_ack(dbus_ack)
    );
endmodule

// File: tb/tb_dbg_scan_bridge.sv
module tb_dbg_scan_bridge;
    logic clk = 0, tck = 0;
    logic rst_n = 0, tck_rst_n = 0;
    logic dr_sel = 0, dr_capture = 0, dr_shift = 0, dr_update = 0, tdi = 0;
    logic tdo;
    logic dbus_req, dbus_wr, dbus_ack = 0;
    logic [7:0]  dbus_addr;
    logic [63:0] dbus_wdata, dbus_rdata = '0;

    always #4  clk = ~clk;
    always #20 tck = ~tck;

    dbg_scan_bridge dut (
        .tck(tck), .tck_rst_n(tck_rst_n), .dr_sel(dr_sel),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .tdo(tdo), .clk(clk), .rst_n(rst_n),
        .dbus_req(dbus_req), .dbus_wr(dbus_wr), .dbus_addr(dbus_addr),
        .dbus_wdata(dbus_wdata), .dbus_rdata(dbus_rdata), .dbus_ack(dbus_ack)
    );

    function automatic logic [63:0] init_val(input logic [7:0] a);
        return 64'h0123_4567_89AB_CDEF ^ {8{a}};
    endfunction

    // Bus target model with address-dependent latency
    logic [63:0] mem [256];
    int          lat_cnt = 0;
    int          txn = 0;
    logic [7:0]  last_addr = 0;
    logic        last_wr = 0;
    logic [63:0] last_wdata = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));

    always @(posedge clk) begin
        dbus_ack <= 1'b0;
        if (dbus_req && !dbus_ack) begin
            if (lat_cnt >= ((dbus_addr == 8'hF0) ? 1000 : int'(dbus_addr[1:0]))) begin
                dbus_ack   <= 1'b1;
                lat_cnt    <= 0;
                txn        <= txn + 1;
                last_addr  <= dbus_addr;
                last_wr    <= dbus_wr;
                last_wdata <= dbus_wdata;
                if (dbus_wr) mem[dbus_addr] <= dbus_wdata;
                else         dbus_rdata     <= mem[dbus_addr];
            end else
                lat_cnt <= lat_cnt + 1;
        end
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [1:0] op, input logic [63:0] d, input logic [7:0] a,
                        output logic [73:0] got);
        logic [73:0] v;
        v = {a, d, op};
        @(negedge tck) dr_sel = 1; dr_capture = 1;
        @(negedge tck) dr_capture = 0; dr_shift = 1;
        for (int i = 0; i < 74; i++) begin
            if (i > 0) @(negedge tck);
            tdi = v[i];
            got[i] = tdo;
        end
        @(negedge tck) dr_shift = 0; dr_update = 1;
        @(negedge tck) dr_update = 0; dr_sel = 0;
    endtask

    // Poll until status 0; returns first status and final capture
    task automatic poll(output logic [1:0] first_st, output logic [73:0] fin);
        logic [73:0] g;
        scan(2'd0, 64'd0, 8'd0, g);
        first_st = g[1:0];
        for (int k = 0; k < 80 && g[1:0] != 2'd0; k++) scan(2'd0, 64'd0, 8'd0, g);
        fin = g;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [63:0] d;
        logic [63:0] e;
    } vec_t;

    localparam logic [63:0] D1 = 64'hA5A5_0000_FFFF_1234;
    localparam logic [63:0] D2 = 64'h8000_0000_0000_0001;
    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 8'h05, 64'h0,         init_val(8'h05)},
        '{2'd2, 8'h05, D1,            init_val(8'h05)},
        '{2'd1, 8'h05, 64'h0,         D1},
        '{2'd0, 8'h00, 64'h0,         D1},
        '{2'd3, 8'h07, 64'hDEAD_BEEF, D1},
        '{2'd1, 8'h07, 64'h0,         init_val(8'h07)},
        '{2'd2, 8'hFF, D2,            init_val(8'h07)},
        '{2'd1, 8'hFF, 64'h0,         D2},
        '{2'd1, 8'h00, 64'h0,         init_val(8'h00)}
    };

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [73:0] g, fin;
        logic [1:0]  fst;
        int          t0;
        logic        launch;
        repeat (5) @(posedge clk);
        rst_n = 1; tck_rst_n = 1;
        repeat (3) @(negedge tck);

        // R1: reset state
        chk("R8 no request after reset", {63'd0, dbus_req}, 64'd0);
        scan(2'd0, 64'd0, 8'd0, g);
        chk("R1 status", {62'd0, g[1:0]}, 64'd0);
        chk("R1 read data", g[65:2], 64'd0);
        chk("R1 addr field", {56'd0, g[73:66]}, 64'd0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            t0 = txn;
            launch = (TBL[v].op == 2'd1 || TBL[v].op == 2'd2);
            scan(TBL[v].op, TBL[v].d, TBL[v].a, g);
            chk("R4 idle status before command", {62'd0, g[1:0]}, 64'd0);
            poll(fst, fin);
            chk(launch ? "R4 busy after launch" : "R6 no busy for nop/reserved",
                {62'd0, fst}, launch ? 64'd3 : 64'd0);
            chk("R4 completes to status 0", {62'd0, fin[1:0]}, 64'd0);
            chk("R2 R9 R7 read data field", fin[65:2], TBL[v].e);
            chk("R6 R8 transaction count", 64'(txn - t0), launch ? 64'd1 : 64'd0);
            if (launch) begin
                chk("R2 R3 bus address", {56'd0, last_addr}, {56'd0, TBL[v].a});
                chk("R2 R3 bus write flag", {63'd0, last_wr}, {63'd0, TBL[v].op == 2'd2});
                if (TBL[v].op == 2'd2)
                    chk("R3 bus write data", last_wdata, TBL[v].d);
            end
        end

        // R5: command while busy is ignored
        t0 = txn;
        scan(2'd1, 64'd0, 8'hF0, g);
        scan(2'd2, 64'h1111_2222_3333_4444, 8'h20, g);
        chk("R4 busy seen by second command", {62'd0, g[1:0]}, 64'd3);
        poll(fst, fin);
        chk("R5 slow read data", fin[65:2], init_val(8'hF0));
        chk("R5 single transaction", 64'(txn - t0), 64'd1);
        chk("R5 bus saw read of F0", {55'd0, last_wr, last_addr}, {55'd0, 1'b0, 8'hF0});
        scan(2'd1, 64'd0, 8'h20, g);
        poll(fst, fin);
        chk("R5 ignored write left target", fin[65:2], init_val(8'h20));

        // R6: reserved op did not write address 07 (reread)
        scan(2'd1, 64'd0, 8'h07, g);
        poll(fst, fin);
        chk("R6 reserved op no write", fin[65:2], init_val(8'h07));

        finish_run();
    end
endmodule